// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block models a synchronous SRAM with a two-stage pipeline. The pipeline lets reads and writes follow each other on consecutive clocks with no idle cycle between them. Each rising edge with the clock enable asserted takes in an address and control set. That set either starts an access, continues the current four-beat burst, or deselects the device. Read data leaves through an output register. Write data is sampled at the same pipeline depth as read data, so the two directions share one slot timing and never collide.

Three chip-select inputs qualify a new access, and a load/advance input chooses between starting and continuing. Four active-low byte-write strobes gate 9-bit lanes of the 36-bit word. A static mode input selects the order of the burst addresses. The output enable acts only on the output drivers. The clock-enable input freezes the whole block. The snooze input drops the block into an idle state that discards all work in flight. The storage depth is set by a package constant and kept small.

Top module: `nt_sram`

## Requirements
- R1: A new access starts only on an enabled edge with advLd low, selAN low, selB high and selCN low. advLd low with any other select pattern deselects the block. A following advLd high edge keeps it deselected: nothing is written and rdDrive stays low for that slot.
- R2: A read issued at enabled edge N places the word on rdData after enabled edge N+2, with rdDrive high if outEnN is low. When rdDrive is low, rdData reads as all zeros.
- R3: The write data of a write issued at enabled edge N is taken from wrData at enabled edge N+2. A read issued on the edge after a write returns that write's data, so writes and reads may alternate every cycle.
- R4: Lane i covers bits [9i+8:9i]. byteWrN[i] low stores that lane, and a lane whose strobe is high keeps its old contents. A write with all four strobes high stores nothing, yet still starts or advances the burst.
- R5: With linearMode high, the two low address bits of beat k (k=0..3) are (start+k) mod 4, and the upper bits stay those of the start address.
- R6: With linearMode low, the two low address bits of beat k are start XOR k. The sequence wraps, so a fifth beat returns to the start address.
- R7: A read with outEnN high leaves rdDrive low, but the burst still advances. outEnN acts asynchronously: lowering it between edges drives the word already in the output register.
- R8: An edge with clkEnN high is ignored. No input is captured, nothing is written, and the output and burst state hold.
- R9: An edge with snooze high empties the pipeline, ends any burst and performs no access. rdDrive is low after that edge, and a write presented during snooze is not stored.
- R10: While rstN is low, the pipeline and burst state clear and rdDrive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high stalls the edge |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| advLd | input | 1 | Low: load a new access; high: continue the burst |
| wrN | input | 1 | Low: write, high: read (sampled on load) |
| byteWrN | input | 4 | Per-lane write strobes, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Power-down request, active high |
| linearMode | input | 1 | Static burst order: high linear, low interleaved |
| addr | input | 6 | Word address |
| wrData | input | 36 | Write data, sampled two enabled edges after its address |
| rdData | output | 36 | Read data, zero when not driven |
| rdDrive | output | 1 | High while rdData carries a valid read word |

## Verification
The assertions assume that rstN is held low for at least one rising edge before traffic starts. They also assume that linearMode only changes while no burst is active, and that snooze and clkEnN change only between edges. The bench drives every input at the falling clock edge, changes linearMode only after several deselect cycles, and releases reset at a falling edge. This keeps the stimulus inside those limits. Burst reads only touch addresses written earlier in the same run, so no expected value depends on the array's power-up contents.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BEAT_W = 2;

  // One pipeline slot: an access waiting for its data phase
  typedef struct packed {
    logic              valid;
    logic              write;
    logic [LANES-1:0]  lanes;
    logic [ADDR_W-1:0] addr;
  } slot_t;

  // Strobes from control to datapath for the current edge
  typedef struct packed {
    logic [LANES-1:0]  wrLanes;
    logic              rdLoad;
    logic [ADDR_W-1:0] addr;
  } strobe_t;

  function automatic logic [BEAT_W-1:0] beatLow(
      input logic [BEAT_W-1:0] start,
      input logic [BEAT_W-1:0] beat,
      input logic              linear);
    return linear ? (start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/nt_sram_ctrl.sv
module nt_sram_ctrl
  import nt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              advLd,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              snooze,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic              rdValid
);

  logic              burstOn, burstOnNxt;
  logic              burstWr, burstWrNxt;
  logic [ADDR_W-1:0] baseAddr, baseAddrNxt;
  logic [BEAT_W-1:0] beat, beatNxt, beatInc;
  slot_t             issue, stage1, stage2;
  logic              live;
  logic              chipSel;

  assign live    = !clkEnN && !snooze;
  assign chipSel = !selAN && selB && !selCN;
  assign beatInc = beat + BEAT_W'(1);

  // Decode of the cycle presented at this edge
  always_comb begin
    burstOnNxt  = burstOn;
    burstWrNxt  = burstWr;
    baseAddrNxt = baseAddr;
    beatNxt     = beat;
    issue       = '0;
    if (!advLd) begin
      if (chipSel) begin
        burstOnNxt  = 1'b1;
        burstWrNxt  = !wrN;
        baseAddrNxt = addr;
        beatNxt     = '0;
        issue.valid = 1'b1;
        issue.write = !wrN;
        issue.lanes = wrN ? '0 : ~byteWrN;
        issue.addr  = addr;
      end else begin
        burstOnNxt = 1'b0;
      end
    end else if (burstOn) begin
      beatNxt     = beatInc;
      issue.valid = 1'b1;
      issue.write = burstWr;
      issue.lanes = burstWr ? ~byteWrN : '0;
      issue.addr  = {baseAddr[ADDR_W-1:BEAT_W],
                     beatLow(baseAddr[BEAT_W-1:0], beatInc, linearMode)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn  <= 1'b0;
      burstWr  <= 1'b0;
      baseAddr <= '0;
      beat     <= '0;
      stage1   <= '0;
      stage2   <= '0;
      rdValid  <= 1'b0;
    end else if (snooze) begin
      burstOn  <= 1'b0;
      stage1   <= '0;
      stage2   <= '0;
      rdValid  <= 1'b0;
    end else if (!clkEnN) begin
      burstOn  <= burstOnNxt;
      burstWr  <= burstWrNxt;
      baseAddr <= baseAddrNxt;
      beat     <= beatNxt;
      stage1   <= issue;
      stage2   <= stage1;
      rdValid  <= stage2.valid && !stage2.write;
    end
  end

  // Data phase of the oldest slot happens at this edge
  always_comb begin
    stb.addr    = stage2.addr;
    stb.wrLanes = (live && stage2.valid && stage2.write) ? stage2.lanes : '0;
    stb.rdLoad  = live && stage2.valid && !stage2.write;
  end

endmodule

// File: rtl/nt_sram_dpath.sv
module nt_sram_dpath
  import nt_sram_pkg::*;
(
  input  logic              clk,
  input  strobe_t           stb,
  input  logic              rdValid,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  logic [DATA_W-1:0] outWord;

  assign rdDrive = rdValid && !outEnN;
  assign rdData  = rdDrive ? outWord : '0;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (stb.wrLanes[g]) laneMem[stb.addr] <= wrData[g*LANE_W +: LANE_W];
      if (stb.rdLoad)     laneQ <= laneMem[stb.addr];
    end

    assign outWord[g*LANE_W +: LANE_W] = laneQ;
  end

endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              advLd,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              outEnN,
  input  logic              snooze,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  strobe_t stb;
  logic    rdValid;

  nt_sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .selAN(selAN), .selB(selB), .selCN(selCN),
    .advLd(advLd), .wrN(wrN), .byteWrN(byteWrN),
    .snooze(snooze), .linearMode(linearMode), .addr(addr),
    .stb(stb), .rdValid(rdValid)
  );

  nt_sram_dpath u_dpath (
    .clk(clk), .stb(stb), .rdValid(rdValid), .outEnN(outEnN),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk
  import nt_sram_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    clkEnN,
  input logic    snooze,
  input strobe_t stb,
  input logic    rdValid
);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !snooze) |=> $stable(rdValid));

  assert_stall_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |-> (stb.wrLanes == '0));

  assert_snooze_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    snooze |=> !rdValid);

  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdLoad |-> (stb.wrLanes == '0));

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(stb.rdLoad));

endmodule

bind nt_sram nt_sram_chk u_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .snooze(snooze),
  .stb(stb), .rdValid(rdValid)
);

// File: tb/sim_nt_sram.sv
module sim_nt_sram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0;
  logic        selAN = 1'b1, selB = 1'b0, selCN = 1'b1;
  logic        advLd = 1'b0, wrN = 1'b1;
  logic [3:0]  byteWrN = 4'hF;
  logic        outEnN = 1'b0;
  logic        snooze = 1'b0;
  logic        linearMode = 1'b1;
  logic [5:0]  addr = '0;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  logic        rdDrive;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  nt_sram u0 (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .selAN(selAN), .selB(selB), .selCN(selCN),
    .advLd(advLd), .wrN(wrN), .byteWrN(byteWrN),
    .outEnN(outEnN), .snooze(snooze), .linearMode(linearMode),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  localparam logic [2:0] SEL = 3'b010;
  localparam logic [35:0] D0 = 36'h111111111, D1 = 36'h222222222,
                          D2 = 36'h333333333, D3 = 36'h444444444,
                          D4 = 36'hABCDE0123;
  localparam logic [35:0] W1 = 36'h123456789, W2 = 36'hFEDCBA987,
                          W3 = 36'h0F0F0F0F0, JUNK = 36'hFFFFFFFFF;

  // {advLd, sel(AN,B,CN), wrN, byteWrN, outEnN, addr, wrData, expDrive, expData}
  localparam int NV = 17;
  localparam logic [88:0] TBL [NV] = '{
    {1'b0, SEL,    1'b0, 4'h0, 1'b0, 6'h05, 36'h0, 1'b0, 36'h0},
    {1'b1, SEL,    1'b0, 4'h0, 1'b0, 6'h00, 36'h0, 1'b0, 36'h0},
    {1'b1, SEL,    1'b0, 4'h0, 1'b0, 6'h00, D0,    1'b0, 36'h0},
    {1'b1, SEL,    1'b0, 4'h0, 1'b0, 6'h00, D1,    1'b0, 36'h0},
    {1'b0, SEL,    1'b1, 4'hF, 1'b0, 6'h05, D2,    1'b0, 36'h0},
    {1'b1, SEL,    1'b1, 4'hF, 1'b0, 6'h00, D3,    1'b0, 36'h0},
    {1'b0, SEL,    1'b0, 4'h0, 1'b0, 6'h20, 36'h0, 1'b1, D0},
    {1'b0, SEL,    1'b1, 4'hF, 1'b0, 6'h06, 36'h0, 1'b1, D1},
    {1'b0, 3'b110, 1'b1, 4'hF, 1'b0, 6'h00, D4,    1'b0, 36'h0},
    {1'b1, 3'b110, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0, 1'b1, D1},
    {1'b0, SEL,    1'b1, 4'hF, 1'b0, 6'h20, 36'h0, 1'b0, 36'h0},
    {1'b0, 3'b000, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0, 1'b0, 36'h0},
    {1'b0, SEL,    1'b1, 4'hF, 1'b0, 6'h07, 36'h0, 1'b1, D4},
    {1'b0, SEL,    1'b1, 4'hF, 1'b0, 6'h04, 36'h0, 1'b0, 36'h0},
    {1'b0, 3'b011, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0, 1'b1, D2},
    {1'b0, 3'b110, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0, 1'b1, D3},
    {1'b0, 3'b110, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0, 1'b0, 36'h0}
  };

  function automatic logic [35:0] merge(input logic [35:0] oldW,
                                        input logic [35:0] newW,
                                        input logic [3:0] bwN);
    logic [35:0] r = oldW;
    for (int i = 0; i < 4; i++)
      if (!bwN[i]) r[i*9 +: 9] = newW[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] pat(input int k);
    return 36'(36'h010101010 * (k + 1) + 36'(k));
  endfunction

  // Drive at the falling edge, pass one rising edge, return at the next falling edge
  task automatic step(input logic adv, input logic [2:0] sel, input logic wr,
                      input logic [3:0] bw, input logic oe, input logic [5:0] a,
                      input logic [35:0] d);
    advLd = adv; selAN = sel[2]; selB = sel[1]; selCN = sel[0];
    wrN = wr; byteWrN = bw; outEnN = oe; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [35:0] d);
    step(1'b0, 3'b110, 1'b1, 4'hF, 1'b0, 6'h00, d);
  endtask

  task automatic check(input string req, input logic expEn, input logic [35:0] expD);
    checks++;
    if (rdDrive !== expEn || rdData !== expD) begin
      errors++;
      $display("FAIL %s: rdDrive=%0b rdData=%h expected rdDrive=%0b rdData=%h",
               req, rdDrive, rdData, expEn, expD);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [88:0] v;
    repeat (3) @(negedge clk);
    check("R10 reset", 1'b0, 36'h0);
    rstN = 1'b1;

    // Table: linear write burst, read burst, deselect patterns (R1 R2 R3 R5)
    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      step(v[88], v[87:85], v[84], v[83:80], v[79], v[78:73], v[72:37]);
      check($sformatf("R1 R2 R3 R5 row %0d", i), v[36], v[35:0]);
    end

    // R3 R4: full write, partial write, then read on the very next edge
    step(1'b0, SEL, 1'b0, 4'h0, 1'b0, 6'h10, 36'h0);
    step(1'b0, SEL, 1'b0, 4'b1010, 1'b0, 6'h10, 36'h0);
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h10, W1);
    idle(W2);
    check("R3 write slot no drive", 1'b0, 36'h0);
    idle(36'h0);
    check("R3 R4 lane merge back-to-back", 1'b1, merge(W1, W2, 4'b1010));

    // R4: write abort still advances the burst
    step(1'b0, SEL, 1'b0, 4'h0, 1'b0, 6'h11, 36'h0);
    idle(36'h0);
    idle(W1);
    step(1'b0, SEL, 1'b0, 4'hF, 1'b0, 6'h11, 36'h0);
    step(1'b1, SEL, 1'b0, 4'h0, 1'b0, 6'h00, 36'h0);
    idle(W2);
    idle(W3);
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h11, 36'h0);
    step(1'b1, SEL, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0);
    idle(36'h0);
    check("R4 aborted write kept old word", 1'b1, W1);
    idle(36'h0);
    check("R4 burst advanced past abort", 1'b1, W3);

    // R6: interleaved write burst from 0x1A, read burst from 0x1B with wrap
    repeat (2) idle(36'h0);
    linearMode = 1'b0;
    repeat (2) idle(36'h0);
    step(1'b0, SEL, 1'b0, 4'h0, 1'b0, 6'h1A, 36'h0);
    step(1'b1, SEL, 1'b0, 4'h0, 1'b0, 6'h00, 36'h0);
    step(1'b1, SEL, 1'b0, 4'h0, 1'b0, 6'h00, pat(0));
    step(1'b1, SEL, 1'b0, 4'h0, 1'b0, 6'h00, pat(1));
    idle(pat(2));
    idle(pat(3));
    // addresses: 1A=pat0, 1B=pat1, 18=pat2, 19=pat3
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h1B, 36'h0);
    step(1'b1, SEL, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0);
    step(1'b1, SEL, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0);
    check("R6 beat0 0x1B", 1'b1, pat(1));
    step(1'b1, SEL, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0);
    check("R6 beat1 0x1A", 1'b1, pat(0));
    step(1'b1, SEL, 1'b1, 4'hF, 1'b0, 6'h00, 36'h0);
    check("R6 beat2 0x19", 1'b1, pat(3));
    idle(36'h0);
    check("R6 beat3 0x18", 1'b1, pat(2));
    idle(36'h0);
    check("R6 beat4 wraps to 0x1B", 1'b1, pat(1));
    repeat (2) idle(36'h0);
    linearMode = 1'b1;
    repeat (2) idle(36'h0);

    // R7: dummy read, asynchronous output enable, burst advance
    step(1'b0, SEL, 1'b1, 4'hF, 1'b1, 6'h05, 36'h0);
    step(1'b1, SEL, 1'b1, 4'hF, 1'b1, 6'h00, 36'h0);
    step(1'b0, 3'b110, 1'b1, 4'hF, 1'b1, 6'h00, 36'h0);
    check("R7 dummy read not driven", 1'b0, 36'h0);
    outEnN = 1'b0;
    #1;
    check("R7 async output enable", 1'b1, D0);
    outEnN = 1'b1;
    #1;
    idle(36'h0);
    check("R7 burst advanced during dummy read", 1'b1, D1);
    idle(36'h0);

    // R8: stall holds output, ignores a write
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h07, 36'h0);
    idle(36'h0);
    idle(36'h0);
    check("R8 before stall", 1'b1, D2);
    clkEnN = 1'b1;
    step(1'b0, SEL, 1'b0, 4'h0, 1'b0, 6'h07, JUNK);
    check("R8 stall holds output", 1'b1, D2);
    step(1'b1, SEL, 1'b0, 4'h0, 1'b0, 6'h00, JUNK);
    check("R8 stall holds output 2", 1'b1, D2);
    clkEnN = 1'b0;
    idle(JUNK);
    check("R8 resume", 1'b0, 36'h0);
    idle(JUNK);
    check("R8 stalled access not issued", 1'b0, 36'h0);
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h07, 36'h0);
    idle(36'h0);
    idle(36'h0);
    check("R8 stalled write not stored", 1'b1, D2);

    // R9: snooze flushes the pipeline and blocks a write
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h04, 36'h0);
    idle(36'h0);
    snooze = 1'b1;
    idle(36'h0);
    check("R9 read flushed by snooze", 1'b0, 36'h0);
    step(1'b0, SEL, 1'b0, 4'h0, 1'b0, 6'h04, JUNK);
    check("R9 snooze no drive", 1'b0, 36'h0);
    snooze = 1'b0;
    step(1'b1, SEL, 1'b0, 4'h0, 1'b0, 6'h00, JUNK);
    idle(JUNK);
    idle(JUNK);
    check("R9 burst ended by snooze", 1'b0, 36'h0);
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h04, 36'h0);
    idle(36'h0);
    idle(36'h0);
    check("R9 write during snooze not stored", 1'b1, D3);

    // R10: reset in flight clears a pending read
    step(1'b0, SEL, 1'b1, 4'hF, 1'b0, 6'h04, 36'h0);
    rstN = 1'b0;
    #1;
    idle(36'h0);
    rstN = 1'b1;
    idle(36'h0);
    check("R10 reset clears pipeline", 1'b0, 36'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule